// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block is a byte-wide register file placed behind a serial management interface. The interface itself is reduced here to a plain address, write-data, write-strobe, read-strobe and read-data port. The bank holds three kinds of register:

- ordinary read/write control bytes, which drive the hardware at once;
- fixed identification bytes and a lock-status byte, which can only be read;
- shadowed configuration bytes for the frequency-synthesis loop and for the phase aligner.

A host write to a shadowed byte changes only its shadow copy. The working copy, which drives the hardware, stays as it was. It takes the shadow value only when a command byte is written to the write-only command address. The command byte is decoded per nibble:

- A high nibble equal to the loop key commits the three loop bytes and pulses the loop reset output for one cycle.
- A low nibble equal to the aligner key commits the aligner byte and pulses the aligner reset output.
- A byte that matches both keys does both.

Reads come back one clock after the read strobe and hold until the next read. Reading a shadowed address returns the shadow copy. The working copy is seen only on the output fields.

Top module: `ctlbank_top`

## Requirements
- R1: After reset, reads return 0x41 at 0x00, 0x00 at 0x01, 0xFF at 0x02, 0x0F at 0x03, 0x03 at 0x05 and 0x1D at 0x06.
- R2: After reset, with no command write, the working outputs equal the shadow reset values: `cp_gain`=0, `post_div_sel`=0, `fb_div`=0xFFF, `aln_res`=3.
- R3: A write to 0x01, 0x02, 0x03 or 0x05 changes the value read back from that address but leaves the working outputs unchanged. The fields are: 0x01 bits 2:0 = `cp_gain`, 0x01 bits 5:4 = `post_div_sel`, 0x02 = `fb_div[7:0]`, 0x03 bits 3:0 = `fb_div[11:8]`, 0x05 bits 1:0 = `aln_res`.
- R4: Bits 3 and 7:6 of 0x01 and bits 7:4 of 0x03 always read 0. Bits 7:2 of 0x05 always read the fixed revision value, which is 0.
- R5: Writing to 0x08 a byte whose bits 7:4 equal 0x5 copies the shadows of 0x01–0x03 into the working outputs. The copy is seen the cycle after the write edge.
- R6: Writing to 0x08 a byte whose bits 3:0 equal 0xA copies the shadow of 0x05 into `aln_res`. 0x5A commits both groups. A byte matching neither key commits nothing.
- R7: Each commit raises its reset pulse (`pll_rst_pulse` for the loop, `aln_rst_pulse` for the aligner) for exactly one cycle. The pulse is in the same cycle that the working outputs change.
- R8: 0x10 reads 0x18 and 0x11 reads 0x01. Writes to them have no effect.
- R9: 0x12 reads `aln_locked` in bit 0 and `pll_locked` in bit 1, with bits 7:2 read as 0.
- R10: 0x00 and 0x06 are full-byte read/write. Their value appears on `in_ctl` and `out_en_ctl` the cycle after the write edge. In 0x06, bits 7:6 are the output scaler code: 0=÷1, 1=÷2, 2=÷4, 3=÷8.
- R11: Reads of 0x08 or of an unmapped address return 0x00. Writes to unmapped addresses change no register.
- R12: `reg_rdata` updates one cycle after a `reg_rd` edge and holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_rd | input | 1 | Read strobe |
| aln_locked | input | 1 | Aligner lock status |
| pll_locked | input | 1 | Loop lock status |
| reg_rdata | output | 8 | Registered read data |
| in_ctl | output | 8 | Value of control byte 0x00 |
| out_en_ctl | output | 8 | Value of output-enable byte 0x06 |
| cp_gain | output | 3 | Working pump gain code |
| post_div_sel | output | 2 | Working post-divider code |
| fb_div | output | 12 | Working feedback divider |
| aln_res | output | 2 | Working aligner resolution code |
| pll_rst_pulse | output | 1 | One-cycle loop reset and commit pulse |
| aln_rst_pulse | output | 1 | One-cycle aligner reset and commit pulse |

## Verification
The bench builds the bank with its default parameters:

- loop key 0x5 and aligner key 0xA;
- identification bytes 0x18 and 0x01;
- revision field 0.

With these values, the bench can drive random command bytes that hit only the high nibble, only the low nibble, both keys (0x5A), or neither. It can therefore reach every commit combination. Because the reset values are fixed at their defaults, random writes can be mixed with shadow-versus-working comparisons from the first cycle after reset.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NUM_LOOP_REGS = 3;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t A_INCTL = 8'h00;
    localparam byte_t A_LOOP  = 8'h01;
    localparam byte_t A_FBLO  = 8'h02;
    localparam byte_t A_FBHI  = 8'h03;
    localparam byte_t A_ALIGN = 8'h05;
    localparam byte_t A_OUTEN = 8'h06;
    localparam byte_t A_CMD   = 8'h08;
    localparam byte_t A_IDV   = 8'h10;
    localparam byte_t A_IDR   = 8'h11;
    localparam byte_t A_STAT  = 8'h12;

    typedef enum logic [3:0] {
        RS_ZERO, RS_INCTL, RS_LOOP, RS_FBLO, RS_FBHI,
        RS_ALIGN, RS_OUTEN, RS_IDV, RS_IDR, RS_STAT
    } rsel_e;

    typedef struct packed {
        logic pll;
        logic aln;
    } commit_t;

    typedef struct packed {
        logic [2:0]  cp_gain;
        logic [1:0]  post_sel;
        logic [11:0] fb_div;
    } loop_cfg_t;

    function automatic rsel_e decode_addr(input byte_t a);
        case (a)
            A_INCTL: return RS_INCTL;
            A_LOOP:  return RS_LOOP;
            A_FBLO:  return RS_FBLO;
            A_FBHI:  return RS_FBHI;
            A_ALIGN: return RS_ALIGN;
            A_OUTEN: return RS_OUTEN;
            A_IDV:   return RS_IDV;
            A_IDR:   return RS_IDR;
            A_STAT:  return RS_STAT;
            default: return RS_ZERO;
        endcase
    endfunction

    function automatic commit_t decode_cmd(input byte_t d, input logic [3:0] pll_key,
                                           input logic [3:0] aln_key);
        commit_t c;
        c.pll = (d[7:4] == pll_key);
        c.aln = (d[3:0] == aln_key);
        return c;
    endfunction

    function automatic byte_t loop_addr(input int idx);
        return A_LOOP + byte_t'(idx);
    endfunction

    function automatic byte_t loop_rst(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'hFF;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic byte_t loop_mask(input int idx);
        case (idx)
            0:       return 8'h37;
            1:       return 8'hFF;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic loop_cfg_t unpack_loop(input byte_t r0, input byte_t r1, input byte_t r2);
        loop_cfg_t c;
        c.cp_gain  = r0[2:0];
        c.post_sel = r0[5:4];
        c.fb_div   = {r2[3:0], r1};
        return c;
    endfunction

endpackage

// File: rtl/ctlbank_plainreg.sv
module ctlbank_plainreg
    import ctlbank_pkg::*;
#(
    parameter byte_t RST_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  byte_t wdata,
    output byte_t value
);

    always_ff @(posedge clk) begin
        if (rst)         value <= RST_VAL;
        else if (wr_hit) value <= wdata;
    end

endmodule

// File: rtl/ctlbank_dbuf.sv
module ctlbank_dbuf
    import ctlbank_pkg::*;
#(
    parameter byte_t RST_VAL = 8'h00,
    parameter byte_t WMASK   = 8'hFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  byte_t wdata,
    input  logic  commit,
    output byte_t shadow,
    output byte_t working
);

    localparam byte_t RST_MASKED = RST_VAL & WMASK;

    always_ff @(posedge clk) begin
        if (rst)         shadow <= RST_MASKED;
        else if (wr_hit) shadow <= wdata & WMASK;
    end

    always_ff @(posedge clk) begin
        if (rst)         working <= RST_MASKED;
        else if (commit) working <= shadow;
    end

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(working)) else $error("working copy moved without commit"); // R3

endmodule

// File: rtl/ctlbank_cmd.sv
module ctlbank_cmd
    import ctlbank_pkg::*;
#(
    parameter logic [3:0] PLL_KEY = 4'h5,
    parameter logic [3:0] ALN_KEY = 4'hA
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_hit,
    input  byte_t   wdata,
    output commit_t commit,
    output commit_t pulse
);

    always_comb begin
        commit = '0;
        if (wr_hit) commit = decode_cmd(wdata, PLL_KEY, ALN_KEY);
    end

    always_ff @(posedge clk) begin
        if (rst) pulse <= '0;
        else     pulse <= commit;
    end

endmodule

// File: rtl/ctlbank_rdport.sv
module ctlbank_rdport
    import ctlbank_pkg::*;
#(
    parameter byte_t      ID_VER   = 8'h18,
    parameter byte_t      ID_REV   = 8'h01,
    parameter logic [5:0] REV_CODE = 6'd0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rd,
    input  byte_t addr,
    input  byte_t inctl,
    input  byte_t loop0,
    input  byte_t loop1,
    input  byte_t loop2,
    input  byte_t align,
    input  byte_t outen,
    input  logic  aln_locked,
    input  logic  pll_locked,
    output byte_t rdata
);

    rsel_e sel;
    byte_t mux;

    assign sel = decode_addr(addr);

    always_comb begin
        unique case (sel)
            RS_INCTL: mux = inctl;
            RS_LOOP:  mux = loop0;
            RS_FBLO:  mux = loop1;
            RS_FBHI:  mux = loop2;
            RS_ALIGN: mux = {REV_CODE, align[1:0]};
            RS_OUTEN: mux = outen;
            RS_IDV:   mux = ID_VER;
            RS_IDR:   mux = ID_REV;
            RS_STAT:  mux = {6'd0, pll_locked, aln_locked};
            default:  mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= mux;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd) |-> $stable(rdata)) else $error("read data moved without strobe"); // R12
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && decode_addr(addr) == RS_ZERO) |=> (rdata == '0)) else $error("unmapped read nonzero"); // R11
    AST_STAT_RSVD: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_STAT) |=> (rdata[7:2] == '0)) else $error("status reserved bits set"); // R9
    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_IDV) |=> (rdata == ID_VER)) else $error("id byte wrong"); // R8

endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
    import ctlbank_pkg::*;
#(
    parameter logic [3:0] PLL_KEY   = 4'h5,
    parameter logic [3:0] ALN_KEY   = 4'hA,
    parameter byte_t      ID_VER    = 8'h18,
    parameter byte_t      ID_REV    = 8'h01,
    parameter logic [5:0] REV_CODE  = 6'd0,
    parameter byte_t      INCTL_RST = 8'h41,
    parameter byte_t      OUTEN_RST = 8'h1D,
    parameter byte_t      ALIGN_RST = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        aln_locked,
    input  logic        pll_locked,
    output logic [7:0]  reg_rdata,
    output logic [7:0]  in_ctl,
    output logic [7:0]  out_en_ctl,
    output logic [2:0]  cp_gain,
    output logic [1:0]  post_div_sel,
    output logic [11:0] fb_div,
    output logic [1:0]  aln_res,
    output logic        pll_rst_pulse,
    output logic        aln_rst_pulse
);

    commit_t   commit, pulse;
    byte_t     loop_sh [NUM_LOOP_REGS];
    byte_t     loop_wk [NUM_LOOP_REGS];
    byte_t     align_sh, align_wk;
    loop_cfg_t loop_cfg;

    ctlbank_plainreg #(.RST_VAL(INCTL_RST)) u_inctl (
        .clk(clk), .rst(rst), .wr_hit(reg_wr && reg_addr == A_INCTL),
        .wdata(reg_wdata), .value(in_ctl));

    ctlbank_plainreg #(.RST_VAL(OUTEN_RST)) u_outen (
        .clk(clk), .rst(rst), .wr_hit(reg_wr && reg_addr == A_OUTEN),
        .wdata(reg_wdata), .value(out_en_ctl));

    ctlbank_cmd #(.PLL_KEY(PLL_KEY), .ALN_KEY(ALN_KEY)) u_cmd (
        .clk(clk), .rst(rst), .wr_hit(reg_wr && reg_addr == A_CMD),
        .wdata(reg_wdata), .commit(commit), .pulse(pulse));

    for (genvar gi = 0; gi < NUM_LOOP_REGS; gi++) begin : g_loop
        ctlbank_dbuf #(.RST_VAL(loop_rst(gi)), .WMASK(loop_mask(gi))) u_reg (
            .clk(clk), .rst(rst), .wr_hit(reg_wr && reg_addr == loop_addr(gi)),
            .wdata(reg_wdata), .commit(commit.pll),
            .shadow(loop_sh[gi]), .working(loop_wk[gi]));
    end

    ctlbank_dbuf #(.RST_VAL(ALIGN_RST), .WMASK(8'h03)) u_align (
        .clk(clk), .rst(rst), .wr_hit(reg_wr && reg_addr == A_ALIGN),
        .wdata(reg_wdata), .commit(commit.aln),
        .shadow(align_sh), .working(align_wk));

    ctlbank_rdport #(.ID_VER(ID_VER), .ID_REV(ID_REV), .REV_CODE(REV_CODE)) u_rd (
        .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
        .inctl(in_ctl), .loop0(loop_sh[0]), .loop1(loop_sh[1]), .loop2(loop_sh[2]),
        .align(align_sh), .outen(out_en_ctl),
        .aln_locked(aln_locked), .pll_locked(pll_locked), .rdata(reg_rdata));

    assign loop_cfg      = unpack_loop(loop_wk[0], loop_wk[1], loop_wk[2]);
    assign cp_gain       = loop_cfg.cp_gain;
    assign post_div_sel  = loop_cfg.post_sel;
    assign fb_div        = loop_cfg.fb_div;
    assign aln_res       = align_wk[1:0];
    assign pll_rst_pulse = pulse.pll;
    assign aln_rst_pulse = pulse.aln;

    AST_PLL_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        pll_rst_pulse |-> $past(reg_wr && reg_addr == A_CMD && reg_wdata[7:4] == PLL_KEY))
        else $error("loop pulse without command"); // R5
    AST_ALN_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        aln_rst_pulse |-> $past(reg_wr && reg_addr == A_CMD && reg_wdata[3:0] == ALN_KEY))
        else $error("aligner pulse without command"); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (pll_rst_pulse && !$past(reg_wr && reg_addr == A_CMD)) |=> !pll_rst_pulse)
        else $error("loop pulse too long"); // R7
    AST_FB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pll_rst_pulse |-> $stable(fb_div)) else $error("divider moved without pulse"); // R7

endmodule

// File: tb/ctlbank_top_bench.sv
module ctlbank_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0, reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic        aln_locked = 1'b0, pll_locked = 1'b0;
    logic [7:0]  reg_rdata, in_ctl, out_en_ctl;
    logic [2:0]  cp_gain;
    logic [1:0]  post_div_sel, aln_res;
    logic [11:0] fb_div;
    logic        pll_rst_pulse, aln_rst_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_in, m_oe, s1, s2, s3, s5, w1, w2, w3, w5;

    always #2 clk = ~clk;

    ctlbank_top u_ctlbank_top (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .aln_locked(aln_locked), .pll_locked(pll_locked),
        .reg_rdata(reg_rdata), .in_ctl(in_ctl), .out_en_ctl(out_en_ctl), .cp_gain(cp_gain),
        .post_div_sel(post_div_sel), .fb_div(fb_div), .aln_res(aln_res),
        .pll_rst_pulse(pll_rst_pulse), .aln_rst_pulse(aln_rst_pulse));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_in;
            8'h01: return s1;
            8'h02: return s2;
            8'h03: return s3;
            8'h05: return {6'd0, s5[1:0]};
            8'h06: return m_oe;
            8'h10: return 8'h18;
            8'h11: return 8'h01;
            8'h12: return {6'd0, pll_locked, aln_locked};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk_outputs(input string req);
        chk({req, " in_ctl"}, in_ctl, m_in);
        chk({req, " out_en_ctl"}, out_en_ctl, m_oe);
        chk({req, " cp_gain"}, cp_gain, w1[2:0]);
        chk({req, " post_div_sel"}, post_div_sel, w1[5:4]);
        chk({req, " fb_div"}, fb_div, {w3[3:0], w2});
        chk({req, " aln_res"}, aln_res, w5[1:0]);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 8'hEE;
        chk(req, reg_rdata, e);
        @(negedge clk);
        chk("R12 hold", reg_rdata, e);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        logic ep, ea;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        ep = (a == 8'h08) && (d[7:4] == 4'h5);
        ea = (a == 8'h08) && (d[3:0] == 4'hA);
        if (ep) begin w1 = s1; w2 = s2; w3 = s3; end
        if (ea) w5 = s5;
        case (a)
            8'h00: m_in = d;
            8'h01: s1 = d & 8'h37;
            8'h02: s2 = d;
            8'h03: s3 = d & 8'h0F;
            8'h05: s5 = d & 8'h03;
            8'h06: m_oe = d;
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'hEE;
        chk("R5 loop pulse", pll_rst_pulse, ep);
        chk("R6 aligner pulse", aln_rst_pulse, ea);
        chk_outputs("R3/R10 after write");
        @(negedge clk);
        chk("R7 loop pulse width", pll_rst_pulse, 1'b0);
        chk("R7 aligner pulse width", aln_rst_pulse, 1'b0);
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] amap [12];
        amap = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h08, 8'h10, 8'h11, 8'h12, 8'h04, 8'hFF};
        seed = $urandom(32'd1234);
        m_in = 8'h41; m_oe = 8'h1D;
        s1 = 8'h00; s2 = 8'hFF; s3 = 8'h0F; s5 = 8'h03;
        w1 = s1; w2 = s2; w3 = s3; w5 = s5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset working", fb_div, 12'hFFF);
        chk("R2 reset aln_res", aln_res, 2'd3);
        chk("R7 idle pulses", {pll_rst_pulse, aln_rst_pulse}, 2'b00);
        chk_outputs("R2 reset");
        foreach (amap[i]) do_read(amap[i], "R1/R8/R11 reset read");

        do_write(8'h01, 8'hFF);  do_read(8'h01, "R4 reserved bits of 0x01");
        do_write(8'h03, 8'hF7);  do_read(8'h03, "R4 reserved bits of 0x03");
        do_write(8'h05, 8'hFE);  do_read(8'h05, "R4 revision bits of 0x05");
        do_write(8'h02, 8'h3C);  chk_outputs("R3 shadow only");
        do_write(8'h08, 8'h50);  chk("R5 divider committed", fb_div, 12'h73C);
        do_write(8'h08, 8'h0A);  chk("R6 aligner committed", aln_res, 2'd2);
        do_write(8'h02, 8'h11);  do_write(8'h05, 8'h01);
        do_write(8'h08, 8'h33);  chk("R6 no-key command", fb_div, 12'h73C);
        do_write(8'h08, 8'h5A);  chk("R6 both commit", {fb_div, aln_res}, {12'h711, 2'd1});
        do_write(8'h10, 8'h00);  do_read(8'h10, "R8 id write ignored");
        do_write(8'h04, 8'hAA);  do_read(8'h04, "R11 unmapped write");
        do_write(8'h06, 8'hC0);  chk("R10 scaler code", out_en_ctl[7:6], 2'd3);
        aln_locked = 1'b1; do_read(8'h12, "R9 aligner lock");
        pll_locked = 1'b1; aln_locked = 1'b0; do_read(8'h12, "R9 loop lock");

        for (int k = 0; k < 400; k++) begin
            logic [7:0] a, d;
            a = amap[$urandom_range(0, 11)];
            d = 8'($urandom);
            if (a == 8'h08 && $urandom_range(0, 1) == 1) d = {4'h5, 4'hA} ^ {($urandom_range(0,1) ? 4'h0 : 4'h3), ($urandom_range(0,1) ? 4'h0 : 4'h6)};
            {aln_locked, pll_locked} = 2'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a, "R1/R3/R9/R11 random read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule